// File: doc/BRIEF.md
# Speculative Load Fault Log

This block keeps a small indexed bank of fault records for loads that were issued speculatively and must not trap at once. When such a load hits an alignment problem, the pipeline asks the block to record it in the lowest free entry, together with the load's effective address. Later instructions consult the bank in three ways. A clear instruction discards records of one register class, either for one destination register or for all of them. A commit instruction with a pending fault flag discards the matching records and raises a commit exception. A store whose address equals a recorded address causes the block to request invalidation of that cache block and to forward the store data to the destination register of the record.

A control register, written in one cycle, holds a valid bit, a logging enable and the number of implemented entries. The block does not touch the register file or the cache itself. It issues registered request outputs one cycle after each operation, and the surrounding logic carries them out. One operation is accepted per cycle. A combinational inspection port lets the core read any entry's status word and address register.

Top module: `spec_fault_log`

## Requirements
- R1: After reset the control register, every status word and every address register are zero, and all response outputs are low.
- R2: The control word written by `cfg_wdata` has bit 5 = valid, bit 4 = logging enable and bits 3:0 = implemented entry count. While the valid bit is clear, a record operation allocates nothing, a store matches nothing, and clear and commit change no entry.
- R3: A record operation (`op_code` 0) with valid and logging enable set writes the lowest-index entry below the entry count whose valid bit is clear, and reports `alloc_ok` with that index. With logging disabled it does nothing.
- R4: If no entry below the entry count is free, a record operation raises `alloc_err` and changes no entry. This includes free entries at or above the count.
- R5: A recorded status word has bit 15 = valid, bit 14 = address valid, bit 13 = float class, bits 12:10 = its own index, bits 9:8 = access size code, bits 7:2 = destination register, bit 1 = register-alignment error and bit 0 = memory-alignment error. Its address register holds `op_addr`.
- R6: A clear operation (`op_code` 1) with valid and logging enable set zeroes the status word and address register of every valid entry below the count whose class equals `op_fp` and whose destination equals `op_dst`, or of every such entry when `op_all` is set. Entries of the other class or of another destination are unchanged, and with logging disabled nothing changes.
- R7: A commit operation (`op_code` 2) with `op_pending`, valid and logging enable set clears entries by the rule of R6 and raises `commit_exc`. Without the pending flag, or with logging disabled, it changes nothing and raises nothing.
- R8: A store operation (`op_code` 3) under a valid control word compares `op_addr` with the address register of each valid entry below the count. On a match it raises `inval_req` with that address and `fwd_valid`, using only the lowest-index match. The logging enable plays no part in this.
- R9: Forwarded data follows the store size code (0 byte, 1 halfword, 2 word, 3 doubleword). A byte is zero-extended from bits 7:0 and a halfword from bits 15:0, and each of these gives one word. A word uses bits 31:0 and gives one word. A doubleword gives two words, low word first, to `fwd_dst` and `fwd_dst`+1. `fwd_fp` and `fwd_dst` come from the matching entry.
- R10: Responses are registered. They appear in the cycle after the operation and last one cycle, and all response outputs are low in a cycle that follows no response-producing operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 6 | Control word: valid, logging enable, entry count |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 record, 1 clear, 2 commit, 3 store |
| op_addr | input | 32 | Load effective address or store address |
| op_dst | input | 6 | Destination register for record or clear/commit match |
| op_all | input | 1 | Clear/commit applies to every destination |
| op_fp | input | 1 | Register class: 1 float, 0 integer |
| op_size | input | 2 | Access size code |
| op_reg_err | input | 1 | Register-alignment error of the faulting load |
| op_mem_err | input | 1 | Memory-alignment error of the faulting load |
| op_pending | input | 1 | Fault flag pending at commit |
| op_wdata | input | 64 | Store data |
| rd_idx | input | 3 | Inspection index |
| rd_status | output | 16 | Status word of entry `rd_idx` |
| rd_addr | output | 32 | Address register of entry `rd_idx` |
| alloc_ok | output | 1 | Record operation allocated an entry |
| alloc_err | output | 1 | Record operation found no free entry |
| alloc_idx | output | 3 | Index allocated |
| commit_exc | output | 1 | Commit exception request |
| inval_req | output | 1 | Cache block invalidation request |
| inval_addr | output | 32 | Address to invalidate |
| fwd_valid | output | 1 | Store data forwarding request |
| fwd_fp | output | 1 | Class of the forwarding destination |
| fwd_dst | output | 6 | First forwarding destination register |
| fwd_words | output | 2 | Number of 32-bit words to forward |
| fwd_data | output | 64 | Forwarded data, low word to `fwd_dst` |

## Verification
The hardest case to reach is a store that matches more than one entry. It only arises when two faulting loads with the same effective address have been recorded. The stimulus records a second load at an address already held by a lower entry and then stores to it, so the lowest-index rule decides which destination and class appear. A second hard case is a bank that is full below the programmed count while higher entries are free. The bench reaches it by lowering the count after three records and then raising it again to show that allocation resumes at the first index above the old limit.

// File: rtl/spec_fault_pkg.sv
package spec_fault_pkg;

  typedef enum logic [1:0] {
    OP_LOG    = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_STORE  = 2'd3
  } sfl_op_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

endpackage

// File: rtl/sfl_store_fwd.sv
module sfl_store_fwd
  import spec_fault_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        words_o
);
  // R9: narrow stores are zero-extended into a single word
  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        data_o  = DATA_W'(data_i[7:0]);
        words_o = 2'd1;
      end
      SZ_HALF: begin
        data_o  = DATA_W'(data_i[15:0]);
        words_o = 2'd1;
      end
      SZ_WORD: begin
        data_o  = DATA_W'(data_i[WORD_W-1:0]);
        words_o = 2'd1;
      end
      default: begin
        data_o  = data_i;
        words_o = 2'd2;
      end
    endcase
  end
endmodule

// File: rtl/sfl_first_hit.sv
module sfl_first_hit #(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set bit is the last one written
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sfl_entry_bank.sv
module sfl_entry_bank #(
  parameter  int N     = 8,
  parameter  int ST_W  = 16,
  parameter  int AW    = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [ST_W-1:0]         wr_st,
  input  logic [AW-1:0]           wr_ad,
  input  logic [N-1:0]            clr_vec,
  output logic [N-1:0][ST_W-1:0]  st_q,
  output logic [N-1:0][AW-1:0]    ad_q
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic            hit_wr;
    logic            ent_en;
    logic [ST_W-1:0] st_d, st_r;
    logic [AW-1:0]   ad_d, ad_r;

    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));
    assign ent_en = clr_vec[g] | hit_wr;

    // R6: clearing zeroes the status word and its address register together
    always_comb begin
      if (clr_vec[g]) begin
        st_d = '0;
        ad_d = '0;
      end else begin
        st_d = wr_st;
        ad_d = wr_ad;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r <= '0;
        ad_r <= '0;
      end else if (ent_en) begin
        st_r <= st_d;
        ad_r <= ad_d;
      end
    end

    assign st_q[g] = st_r;
    assign ad_q[g] = ad_r;
  end
endmodule

// File: rtl/spec_fault_log.sv
module spec_fault_log
  import spec_fault_pkg::*;
#(
  parameter  int ENTRIES = 8,
  parameter  int AW      = 32,
  parameter  int REG_W   = 6,
  parameter  int WORD_W  = 32,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int CTL_W   = CNT_W + 2,
  localparam int DATA_W  = 2 * WORD_W,
  localparam int ST_W    = 7 + IDX_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTL_W-1:0]  cfg_wdata,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [AW-1:0]     op_addr,
  input  logic [REG_W-1:0]  op_dst,
  input  logic              op_all,
  input  logic              op_fp,
  input  logic [1:0]        op_size,
  input  logic              op_reg_err,
  input  logic              op_mem_err,
  input  logic              op_pending,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ST_W-1:0]   rd_status,
  output logic [AW-1:0]     rd_addr,
  output logic              alloc_ok,
  output logic              alloc_err,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              commit_exc,
  output logic              inval_req,
  output logic [AW-1:0]     inval_addr,
  output logic              fwd_valid,
  output logic              fwd_fp,
  output logic [REG_W-1:0]  fwd_dst,
  output logic [1:0]        fwd_words,
  output logic [DATA_W-1:0] fwd_data
);
  // status word field positions (R5)
  localparam int F_MEM    = 0;
  localparam int F_REG    = 1;
  localparam int F_DST_LO = 2;
  localparam int F_SZ_LO  = F_DST_LO + REG_W;
  localparam int F_IDX_LO = F_SZ_LO + 2;
  localparam int F_FP     = F_IDX_LO + IDX_W;
  localparam int F_AV     = F_FP + 1;
  localparam int F_VLD    = F_AV + 1;

  // ---------------- control register (R2) ----------------
  logic [CTL_W-1:0] ctl_d, ctl_q;
  logic             ctl_vld, ctl_log;
  logic [CNT_W-1:0] ctl_cnt;

  assign ctl_d = cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_we) ctl_q <= ctl_d;
  end

  assign ctl_vld = ctl_q[CTL_W-1];
  assign ctl_log = ctl_q[CNT_W];
  assign ctl_cnt = ctl_q[CNT_W-1:0];

  // ---------------- entry bank ----------------
  logic [ENTRIES-1:0][ST_W-1:0] ent_st;
  logic [ENTRIES-1:0][AW-1:0]   ent_ad;
  logic [ENTRIES-1:0]           ent_vld, in_rng, live, free_v, cls_hit, adr_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign ent_vld[g] = ent_st[g][F_VLD];
    assign in_rng[g]  = (CNT_W'(g) < ctl_cnt);
    assign live[g]    = ctl_vld & in_rng[g] & ent_vld[g];
    assign free_v[g]  = ctl_vld & in_rng[g] & ~ent_vld[g];
    assign cls_hit[g] = live[g] & (ent_st[g][F_FP] == op_fp) &
                        (op_all | (ent_st[g][F_DST_LO +: REG_W] == op_dst));
    assign adr_hit[g] = live[g] & (ent_ad[g] == op_addr);
  end

  // ---------------- operation decode ----------------
  sfl_op_e op_e;
  logic    do_log, do_clear, do_commit, do_store;

  assign op_e      = sfl_op_e'(op_code);
  assign do_log    = op_valid && (op_e == OP_LOG)    && ctl_vld && ctl_log;
  assign do_clear  = op_valid && (op_e == OP_CLEAR)  && ctl_vld && ctl_log;
  assign do_commit = op_valid && (op_e == OP_COMMIT) && ctl_vld && ctl_log && op_pending;
  assign do_store  = op_valid && (op_e == OP_STORE);

  // R3: lowest free entry; R8: lowest address match
  logic             free_found, st_found;
  logic [IDX_W-1:0] free_idx, st_idx;

  sfl_first_hit #(.N(ENTRIES)) u_free_pick (
    .hits_i (free_v),
    .found_o(free_found),
    .idx_o  (free_idx)
  );

  sfl_first_hit #(.N(ENTRIES)) u_addr_pick (
    .hits_i (adr_hit),
    .found_o(st_found),
    .idx_o  (st_idx)
  );

  logic             bank_wr;
  logic [ST_W-1:0]  new_st;
  logic [ENTRIES-1:0] clr_vec;

  assign bank_wr = do_log & free_found;
  assign new_st  = {1'b1, 1'b1, op_fp, free_idx, op_size, op_dst, op_reg_err, op_mem_err};
  assign clr_vec = (do_clear | do_commit) ? cls_hit : '0;

  sfl_entry_bank #(.N(ENTRIES), .ST_W(ST_W), .AW(AW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bank_wr),
    .wr_idx (free_idx),
    .wr_st  (new_st),
    .wr_ad  (op_addr),
    .clr_vec(clr_vec),
    .st_q   (ent_st),
    .ad_q   (ent_ad)
  );

  assign rd_status = ent_st[rd_idx];
  assign rd_addr   = ent_ad[rd_idx];

  // ---------------- store forwarding ----------------
  logic [DATA_W-1:0] fdata;
  logic [1:0]        fwords;
  logic              hit_fp;
  logic [REG_W-1:0]  hit_dst;

  sfl_store_fwd #(.WORD_W(WORD_W)) u_fwd (
    .size_i (op_size),
    .data_i (op_wdata),
    .data_o (fdata),
    .words_o(fwords)
  );

  assign hit_fp  = ent_st[st_idx][F_FP];
  assign hit_dst = ent_st[st_idx][F_DST_LO +: REG_W];

  // ---------------- response stage (R10) ----------------
  logic              ok_d, err_d, cexc_d, inv_d;
  logic [IDX_W-1:0]  idx_d;
  logic [AW-1:0]     iaddr_d;
  logic              ffp_d;
  logic [REG_W-1:0]  fdst_d;
  logic [1:0]        fwords_d;
  logic [DATA_W-1:0] fdata_d;

  always_comb begin
    ok_d     = bank_wr;
    err_d    = do_log & ~free_found;      // R4
    idx_d    = bank_wr ? free_idx : '0;
    cexc_d   = do_commit;                 // R7
    inv_d    = do_store & st_found;       // R8
    iaddr_d  = inv_d ? op_addr : '0;
    ffp_d    = inv_d & hit_fp;
    fdst_d   = inv_d ? hit_dst : '0;
    fwords_d = inv_d ? fwords : '0;
    fdata_d  = inv_d ? fdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_ok   <= 1'b0;
      alloc_err  <= 1'b0;
      alloc_idx  <= '0;
      commit_exc <= 1'b0;
      inval_req  <= 1'b0;
      inval_addr <= '0;
      fwd_valid  <= 1'b0;
      fwd_fp     <= 1'b0;
      fwd_dst    <= '0;
      fwd_words  <= '0;
      fwd_data   <= '0;
    end else begin
      alloc_ok   <= ok_d;
      alloc_err  <= err_d;
      alloc_idx  <= idx_d;
      commit_exc <= cexc_d;
      inval_req  <= inv_d;
      inval_addr <= iaddr_d;
      fwd_valid  <= inv_d;
      fwd_fp     <= ffp_d;
      fwd_dst    <= fdst_d;
      fwd_words  <= fwords_d;
      fwd_data   <= fdata_d;
    end
  end
endmodule

// File: rtl/spec_fault_log_chk.sv
module spec_fault_log_chk #(
  parameter  int ENTRIES = 8,
  parameter  int AW      = 32,
  parameter  int WORD_W  = 32,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int CTL_W   = CNT_W + 2,
  localparam int DATA_W  = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [AW-1:0]     op_addr,
  input logic [1:0]        op_size,
  input logic              op_pending,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [ENTRIES-1:0] ent_vld,
  input logic              alloc_ok,
  input logic              alloc_err,
  input logic [IDX_W-1:0]  alloc_idx,
  input logic              commit_exc,
  input logic              inval_req,
  input logic [AW-1:0]     inval_addr,
  input logic              fwd_valid,
  input logic [1:0]        fwd_words,
  input logic [DATA_W-1:0] fwd_data
);
  p_ctl_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ctl_q[CTL_W-1]) |=> !(alloc_ok || alloc_err || commit_exc || inval_req));

  p_alloc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (CNT_W'(alloc_idx) < $past(ctl_q[CNT_W-1:0])));

  p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (ent_vld[alloc_idx] &&
                  ((($past(ent_vld) >> alloc_idx) & ENTRIES'(1)) == '0)));

  p_full_nochange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> $stable(ent_vld));

  p_commit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_exc |-> $past(op_valid && (op_code == 2'd2) && op_pending));

  p_inval_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |-> (fwd_valid && (inval_addr == $past(op_addr)) && ($past(op_code) == 2'd3)));

  p_byte_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && ($past(op_size) == 2'd0)) |-> ((fwd_data[DATA_W-1:8] == '0) && (fwd_words == 2'd1)));

  p_one_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_ok, alloc_err, commit_exc, inval_req}));
endmodule

bind spec_fault_log spec_fault_log_chk #(
  .ENTRIES(ENTRIES), .AW(AW), .WORD_W(WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_addr   (op_addr),
  .op_size   (op_size),
  .op_pending(op_pending),
  .ctl_q     (ctl_q),
  .ent_vld   (ent_vld),
  .alloc_ok  (alloc_ok),
  .alloc_err (alloc_err),
  .alloc_idx (alloc_idx),
  .commit_exc(commit_exc),
  .inval_req (inval_req),
  .inval_addr(inval_addr),
  .fwd_valid (fwd_valid),
  .fwd_words (fwd_words),
  .fwd_data  (fwd_data)
);

// File: tb/spec_fault_log_bench.sv
module spec_fault_log_bench;
  import spec_fault_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [31:0] op_addr = '0;
  logic [5:0]  op_dst = '0;
  logic        op_all = 1'b0;
  logic        op_fp = 1'b0;
  logic [1:0]  op_size = '0;
  logic        op_reg_err = 1'b0;
  logic        op_mem_err = 1'b0;
  logic        op_pending = 1'b0;
  logic [63:0] op_wdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_status;
  logic [31:0] rd_addr;
  logic        alloc_ok, alloc_err, commit_exc, inval_req, fwd_valid, fwd_fp;
  logic [2:0]  alloc_idx;
  logic [31:0] inval_addr;
  logic [5:0]  fwd_dst;
  logic [1:0]  fwd_words;
  logic [63:0] fwd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spec_fault_log u_spec_fault_log (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_dst(op_dst),
    .op_all(op_all), .op_fp(op_fp), .op_size(op_size), .op_reg_err(op_reg_err),
    .op_mem_err(op_mem_err), .op_pending(op_pending), .op_wdata(op_wdata),
    .rd_idx(rd_idx), .rd_status(rd_status), .rd_addr(rd_addr),
    .alloc_ok(alloc_ok), .alloc_err(alloc_err), .alloc_idx(alloc_idx),
    .commit_exc(commit_exc), .inval_req(inval_req), .inval_addr(inval_addr),
    .fwd_valid(fwd_valid), .fwd_fp(fwd_fp), .fwd_dst(fwd_dst),
    .fwd_words(fwd_words), .fwd_data(fwd_data)
  );

  typedef struct packed {
    logic        ok;
    logic        err;
    logic [2:0]  idx;
    logic        cexc;
    logic        inv;
    logic [31:0] iaddr;
    logic        fv;
    logic        ffp;
    logic [5:0]  fdst;
    logic [1:0]  fw;
    logic [63:0] fdata;
  } rsp_t;

  typedef struct {
    int    cyc;
    rsp_t  r;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // reference model
  logic [15:0] m_st [8];
  logic [31:0] m_ad [8];
  bit          c_vld = 1'b0, c_log = 1'b0;
  int          c_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      rsp_t act;
      act = {alloc_ok, alloc_err, alloc_idx, commit_exc, inval_req, inval_addr,
             fwd_valid, fwd_fp, fwd_dst, fwd_words, fwd_data};
      checks++;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (act !== e.r) begin
          fails++;
          $display("FAIL %s: response got %h expected %h", e.tag, act, e.r);
        end
      end else if (act !== '0) begin
        fails++;
        $display("FAIL R10 idle cycle: response got %h expected %h", act, rsp_t'(0));
      end
    end
  end

  function automatic logic [15:0] mk_st(logic fp, logic [2:0] idx, logic [1:0] sz,
                                        logic [5:0] dst, logic re, logic me);
    return {1'b1, 1'b1, fp, idx, sz, dst, re, me};
  endfunction

  task automatic cfg(bit v, bit l, int cnt);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {v, l, 4'(cnt)};
    @(posedge clk);
    #1 cfg_we = 1'b0;
    c_vld = v; c_log = l; c_cnt = cnt;
  endtask

  task automatic do_op(sfl_op_e op, logic [31:0] addr, logic [5:0] dst, logic all,
                       logic fp, logic [1:0] sz, logic re, logic me, logic pend,
                       logic [63:0] wd, string tag);
    rsp_t e;
    bit   found;
    int   fi;
    e = '0;
    found = 1'b0;
    fi = 0;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_addr = addr; op_dst = dst; op_all = all;
    op_fp = fp; op_size = sz; op_reg_err = re; op_mem_err = me;
    op_pending = pend; op_wdata = wd;
    case (op)
      OP_LOG: if (c_vld && c_log) begin
        for (int i = 0; i < 8; i++)
          if (!found && i < c_cnt && !m_st[i][15]) begin found = 1'b1; fi = i; end
        if (found) begin
          e.ok = 1'b1; e.idx = 3'(fi);
          m_st[fi] = mk_st(fp, 3'(fi), sz, dst, re, me);
          m_ad[fi] = addr;
        end else e.err = 1'b1;
      end
      OP_CLEAR, OP_COMMIT: if (c_vld && c_log && (op == OP_CLEAR || pend)) begin
        for (int i = 0; i < 8; i++)
          if (i < c_cnt && m_st[i][15] && m_st[i][13] == fp && (all || m_st[i][7:2] == dst)) begin
            m_st[i] = '0; m_ad[i] = '0;
          end
        if (op == OP_COMMIT) e.cexc = 1'b1;
      end
      default: if (c_vld) begin
        for (int i = 0; i < 8; i++)
          if (!found && i < c_cnt && m_st[i][15] && m_ad[i] == addr) begin found = 1'b1; fi = i; end
        if (found) begin
          e.inv = 1'b1; e.iaddr = addr; e.fv = 1'b1;
          e.ffp = m_st[fi][13]; e.fdst = m_st[fi][7:2];
          case (sz)
            2'd0:    begin e.fdata = {56'd0, wd[7:0]};  e.fw = 2'd1; end
            2'd1:    begin e.fdata = {48'd0, wd[15:0]}; e.fw = 2'd1; end
            2'd2:    begin e.fdata = {32'd0, wd[31:0]}; e.fw = 2'd1; end
            default: begin e.fdata = wd;                e.fw = 2'd2; end
          endcase
        end
      end
    endcase
    q.push_back('{cyc + 1, e, tag});
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic chk_entry(int idx, string tag);
    @(negedge clk);
    rd_idx = 3'(idx);
    #1;
    checks++;
    if (rd_status !== m_st[idx] || rd_addr !== m_ad[idx]) begin
      fails++;
      $display("FAIL %s: entry %0d got %h/%h expected %h/%h", tag, idx,
               rd_status, rd_addr, m_st[idx], m_ad[idx]);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: run reached %0d cycles, expected to end earlier", cyc);
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_st[i] = '0; m_ad[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) chk_entry(i, "R1 reset entry");

    // control invalid
    do_op(OP_LOG, 32'h100, 6'd4, 0, 0, 2'd2, 0, 1, 0, '0, "R2 record with invalid control");
    chk_entry(0, "R2 entry untouched");

    cfg(1, 1, 8);
    do_op(OP_LOG, 32'h1000, 6'd10, 0, 0, 2'd2, 0, 1, 0, '0, "R3 record first");
    chk_entry(0, "R5 entry0 layout");
    do_op(OP_LOG, 32'h2000, 6'd11, 0, 1, 2'd3, 1, 0, 0, '0, "R3 record second");
    chk_entry(1, "R5 entry1 layout");
    do_op(OP_LOG, 32'h3000, 6'd12, 0, 0, 2'd1, 0, 1, 0, '0, "R3 record third");

    do_op(OP_CLEAR, '0, 6'd11, 0, 0, 2'd0, 0, 0, 0, '0, "R6 clear wrong class");
    chk_entry(1, "R6 other class kept");
    do_op(OP_CLEAR, '0, 6'd11, 0, 1, 2'd0, 0, 0, 0, '0, "R6 clear float dst11");
    chk_entry(1, "R6 entry1 zeroed");
    do_op(OP_LOG, 32'h4000, 6'd20, 0, 0, 2'd0, 0, 1, 0, '0, "R3 reuse lowest free");

    cfg(1, 1, 3);
    do_op(OP_LOG, 32'h5000, 6'd21, 0, 0, 2'd2, 0, 1, 0, '0, "R4 full below count");
    chk_entry(3, "R4 entry3 untouched");
    cfg(1, 1, 8);
    do_op(OP_LOG, 32'h3000, 6'd30, 0, 1, 2'd3, 1, 1, 0, '0, "R3 record above old count");

    do_op(OP_STORE, 32'h3000, '0, 0, 0, 2'd1, 0, 0, 0, 64'h1122_3344_5566_7788, "R8 lowest of two matches");
    do_op(OP_STORE, 32'h1000, '0, 0, 0, 2'd0, 0, 0, 0, 64'h1122_3344_5566_7788, "R9 byte store");
    do_op(OP_STORE, 32'h4000, '0, 0, 0, 2'd2, 0, 0, 0, 64'hdead_beef_cafe_f00d, "R9 word store");
    do_op(OP_CLEAR, '0, 6'd12, 0, 0, 2'd0, 0, 0, 0, '0, "R6 clear int dst12");
    do_op(OP_STORE, 32'h3000, '0, 0, 0, 2'd3, 0, 0, 0, 64'h0123_4567_89ab_cdef, "R9 doubleword store");
    do_op(OP_STORE, 32'h9999, '0, 0, 0, 2'd2, 0, 0, 0, 64'h1, "R8 no match");

    cfg(1, 0, 8);
    do_op(OP_STORE, 32'h1000, '0, 0, 0, 2'd2, 0, 0, 0, 64'h55, "R8 store with logging off");
    do_op(OP_CLEAR, '0, '0, 1, 0, 2'd0, 0, 0, 0, '0, "R6 clear with logging off");
    chk_entry(0, "R6 logging off keeps entry");
    do_op(OP_COMMIT, '0, '0, 1, 1, 2'd0, 0, 0, 1, '0, "R7 commit with logging off");
    do_op(OP_LOG, 32'h6000, 6'd1, 0, 0, 2'd0, 0, 0, 0, '0, "R3 record with logging off");

    cfg(1, 1, 1);
    do_op(OP_STORE, 32'h4000, '0, 0, 0, 2'd2, 0, 0, 0, 64'h77, "R8 match beyond count");
    do_op(OP_CLEAR, '0, '0, 1, 0, 2'd0, 0, 0, 0, '0, "R6 clear all int below count");
    chk_entry(0, "R6 entry0 cleared");
    chk_entry(1, "R6 entry1 beyond count kept");

    cfg(1, 1, 8);
    do_op(OP_COMMIT, '0, '0, 1, 1, 2'd0, 0, 0, 0, '0, "R7 commit without pending");
    chk_entry(3, "R7 entry3 kept");
    do_op(OP_COMMIT, '0, 6'd30, 0, 1, 2'd0, 0, 0, 1, '0, "R7 commit pending float dst30");
    chk_entry(3, "R7 entry3 cleared");
    do_op(OP_COMMIT, '0, 6'd5, 0, 0, 2'd0, 0, 0, 1, '0, "R7 commit pending no match");
    chk_entry(1, "R7 unmatched entry kept");

    cfg(0, 1, 8);
    do_op(OP_STORE, 32'h4000, '0, 0, 0, 2'd2, 0, 0, 0, 64'h99, "R2 store with invalid control");
    do_op(OP_CLEAR, '0, '0, 1, 0, 2'd0, 0, 0, 0, '0, "R2 clear with invalid control");
    chk_entry(1, "R2 entry1 kept");

    cfg(1, 1, 8);
    do_op(OP_CLEAR, '0, '0, 1, 0, 2'd0, 0, 0, 0, '0, "R6 clear all int");
    chk_entry(1, "R6 entry1 cleared");

    repeat (3) @(negedge clk);
    done = 1'b1;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 pending responses: got %0d expected 0", q.size());
    end
    summary();
  end
endmodule